// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block sits on the host side of a parallel ATA link and performs one programmed-I/O register or data access at a time. A request port takes the direction, the 3-bit register address, the two chip-select lines, the transfer width (16-bit or 8-bit) and the write data. The block then drives the address, the chip-selects, the read and write strobes and the data output enable to the device. For a read it captures the returned data.

The timing mode (0 to 4) is sampled with each request. Every minimum interval in nanoseconds is turned into a clock-cycle count at elaboration, rounding up, from a clock-period parameter. The intervals are address setup, strobe width per transfer width, post-strobe hold and recovery, and total cycle time. The device's IORDY ready line passes through a two-stage synchroniser. Modes 3 and 4 always honour it. Modes 0 to 2 honour it only when an enable input is set. A device that keeps IORDY low too long has its cycle cut short, and the block reports a timeout.

Top module: `ataPioSeq`

## Requirements
- R1: After reset both strobes are high, both chip-selects are high, `ataDdOe`, `busy`, `done` and `timeoutErr` are low, and `rdData` is zero.
- R2: The address and chip-selects (`ataCsN` = inverse of `reqCs`) are valid for exactly ceil(t1 / clock period) cycles before the strobe falls, where t1 is 70, 50, 30, 30 or 25 ns for modes 0 to 4. They stay stable until the cycle ends.
- R3: With IORDY high, the strobe is low for ceil(width / period) cycles. The width is 165, 125, 100, 80 or 70 ns for a 16-bit transfer (`reqWide`=1) and 290, 290, 290, 80 or 70 ns for an 8-bit transfer.
- R4: `busy` lasts max(setup + strobe + N, ceil(t0 / period)) cycles. N is the largest of the address hold (20, 15, 10, 10, 10 ns), write data hold (30, 20, 15, 10, 10 ns) and recovery (0, 0, 0, 70, 25 ns) counts, and t0 is 600, 383, 240, 180 or 120 ns. `done` pulses for one cycle as `busy` falls.
- R5: A read (`reqRnw`=1) pulses only `ataDiorN` and keeps `ataDdOe` low. It loads `rdData` from `ataDdIn` at strobe negation, with bits 15:8 forced to zero for an 8-bit transfer.
- R6: A write pulses only `ataDiowN`, holds `ataDdOe` high for the whole busy period, and drives `ataDdOut` with the write data, with bits 15:8 zero for an 8-bit transfer.
- R7: When IORDY is honoured (modes 3 and 4, or modes 0 to 2 with `rdyEnable`=1), the strobe lasts at least ceil(35 ns / period) + 2 cycles. It also stays low until IORDY, delayed by two sync stages, reads high. In modes 0 to 2 with `rdyEnable`=0, IORDY has no effect.
- R8: If the synchronised IORDY is still low once the strobe has been low for ceil(35 ns / period) + 2 + ceil(1250 ns / period) cycles, the strobe ends. `timeoutErr` is then high during the `done` cycle.
- R9: If the synchronised IORDY rises in the very cycle the timeout limit is reached, the cycle ends normally and `timeoutErr` stays low.
- R10: Mode codes 5, 6 and 7 get mode 0 timing.
- R11: A request is accepted only while `busy` is low. A request raised during a cycle changes neither the bus nor the next state. A request present in the `done` cycle is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqRnw | input | 1 | 1 = read, 0 = write |
| reqWide | input | 1 | 1 = 16-bit, 0 = 8-bit transfer |
| reqAddr | input | 3 | Device register address |
| reqCs | input | 2 | Chip-selects to assert (1 = assert) |
| reqWdata | input | 16 | Write data |
| reqMode | input | 3 | PIO timing mode |
| rdyEnable | input | 1 | Honour IORDY in modes 0 to 2 |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |
| timeoutErr | output | 1 | Cycle ended by IORDY timeout (with done) |
| rdData | output | 16 | Captured read data |
| ataAddr | output | 3 | Device address lines |
| ataCsN | output | 2 | Chip-selects, active low |
| ataDiorN | output | 1 | Read strobe, active low |
| ataDiowN | output | 1 | Write strobe, active low |
| ataDdOut | output | 16 | Data bus output value |
| ataDdOe | output | 1 | Data bus output enable |
| ataDdIn | input | 16 | Data bus input value |
| ataIordy | input | 1 | Device ready, asynchronous |

## Verification
Two functions can resolve in the same cycle. The first is the IORDY wait, which ends the strobe when ready returns. The second is the timeout, which ends it with an error. The bench releases IORDY two cycles before the timeout limit, so the synchronised level arrives in exactly the limit cycle. It then expects the full-length strobe with no error flag, and it checks a stuck-low run that does raise the flag. A second collision is a new request sitting on the port in the `done` cycle. The bench holds the request line high across a whole transfer and judges that the earlier presentation was ignored. It also checks that the new one starts on the very next cycle with its own address.

// File: rtl/ataPioPkg.sv
package ataPioPkg;

  typedef struct packed {
    logic load;     // capture the request fields
    logic active;   // a cycle is in progress
    logic strobe;   // strobe phase (single flop in control)
    logic capture;  // sample read data at strobe negation
  } ctrlStrobeT;

  function automatic int nsToCyc(input int ns, input int clkPs);
    return (ns * 1000 + clkPs - 1) / clkPs;
  endfunction

  function automatic int cycleNs(input int m);
    case (m)
      0: return 600;
      1: return 383;
      2: return 240;
      3: return 180;
      default: return 120;
    endcase
  endfunction

  function automatic int addrSetupNs(input int m);
    case (m)
      0: return 70;
      1: return 50;
      2: return 30;
      3: return 30;
      default: return 25;
    endcase
  endfunction

  function automatic int wideStrobeNs(input int m);
    case (m)
      0: return 165;
      1: return 125;
      2: return 100;
      3: return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int byteStrobeNs(input int m);
    case (m)
      0, 1, 2: return 290;
      3: return 80;
      default: return 70;
    endcase
  endfunction

  function automatic int recoveryNs(input int m);
    case (m)
      3: return 70;
      4: return 25;
      default: return 0;
    endcase
  endfunction

  function automatic int addrHoldNs(input int m);
    case (m)
      0: return 20;
      1: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int dataHoldNs(input int m);
    case (m)
      0: return 30;
      1: return 20;
      2: return 15;
      default: return 10;
    endcase
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ataPioTiming.sv
module ataPioTiming
  import ataPioPkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int CNT_W       = 10,
  parameter int NUM_MODES   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RDY_SAMPLE_NS = 35,
  parameter int RDY_MAX_NS  = 1250
) (
  input  logic [2:0]       modeIdx,
  input  logic             wide,
  input  logic             rdyEn,
  output logic [CNT_W-1:0] setupCyc,
  output logic [CNT_W-1:0] pulseCyc,
  output logic [CNT_W-1:0] negCyc,
  output logic [CNT_W-1:0] totalCyc,
  output logic [CNT_W-1:0] timeoutCyc,
  output logic             honorRdy
);

  localparam int RDY_CYC = nsToCyc(RDY_SAMPLE_NS, CLK_PS) + SYNC_STAGES;
  localparam int TO_CYC  = RDY_CYC + nsToCyc(RDY_MAX_NS, CLK_PS);
  localparam int FIRST_FORCED = 3;  // modes from here on always honour IORDY

  logic [CNT_W-1:0] setupTab [NUM_MODES];
  logic [CNT_W-1:0] wideTab  [NUM_MODES];
  logic [CNT_W-1:0] byteTab  [NUM_MODES];
  logic [CNT_W-1:0] negTab   [NUM_MODES];
  logic [CNT_W-1:0] totalTab [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : gMode
    localparam int SU  = nsToCyc(addrSetupNs(m), CLK_PS);
    localparam int PW  = nsToCyc(wideStrobeNs(m), CLK_PS);
    localparam int PB  = nsToCyc(byteStrobeNs(m), CLK_PS);
    localparam int NG0 = maxOf(nsToCyc(addrHoldNs(m), CLK_PS),
                               nsToCyc(dataHoldNs(m), CLK_PS));
    localparam int NG  = maxOf(maxOf(NG0, nsToCyc(recoveryNs(m), CLK_PS)), 1);
    localparam int TT  = nsToCyc(cycleNs(m), CLK_PS);
    assign setupTab[m] = CNT_W'(maxOf(SU, 1));
    assign wideTab[m]  = CNT_W'(maxOf(PW, 1));
    assign byteTab[m]  = CNT_W'(maxOf(PB, 1));
    assign negTab[m]   = CNT_W'(NG);
    assign totalTab[m] = CNT_W'(TT);
  end

  logic [CNT_W-1:0] basePulse;

  always_comb begin
    setupCyc   = setupTab[modeIdx];
    basePulse  = wide ? wideTab[modeIdx] : byteTab[modeIdx];
    negCyc     = negTab[modeIdx];
    totalCyc   = totalTab[modeIdx];
    honorRdy   = (int'(modeIdx) >= FIRST_FORCED) || rdyEn;
    timeoutCyc = CNT_W'(TO_CYC);
    pulseCyc   = (honorRdy && (basePulse < CNT_W'(RDY_CYC))) ? CNT_W'(RDY_CYC) : basePulse;
  end

endmodule

// File: rtl/ataPioCtrl.sv
module ataPioCtrl
  import ataPioPkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] setupCyc,
  input  logic [CNT_W-1:0] pulseCyc,
  input  logic [CNT_W-1:0] negCyc,
  input  logic [CNT_W-1:0] totalCyc,
  input  logic [CNT_W-1:0] timeoutCyc,
  input  logic             honorRdy,
  input  logic             rdySync,
  output ctrlStrobeT       ctl,
  output logic             doneOut,
  output logic             errOut
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACTIVE, ST_NEGATE} stateT;

  stateT            state;
  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] totalCnt;
  logic             strobeQ;
  logic             doneQ;
  logic             errQ;
  logic             readyExit;
  logic             timeoutExit;
  logic             leaveActive;

  always_comb begin
    readyExit   = (phaseCnt >= pulseCyc) && (!honorRdy || rdySync);
    timeoutExit = honorRdy && !rdySync && (phaseCnt >= timeoutCyc);
    leaveActive = (state == ST_ACTIVE) && (readyExit || timeoutExit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      totalCnt <= '0;
      strobeQ  <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (state != ST_IDLE) totalCnt <= totalCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_SETUP;
            phaseCnt <= CNT_W'(1);
            totalCnt <= CNT_W'(1);
            errQ     <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (phaseCnt >= setupCyc) begin
            state    <= ST_ACTIVE;
            strobeQ  <= 1'b1;
            phaseCnt <= CNT_W'(1);
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (leaveActive) begin
            state    <= ST_NEGATE;
            strobeQ  <= 1'b0;
            phaseCnt <= CNT_W'(1);
            errQ     <= !readyExit;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: begin
          if ((phaseCnt >= negCyc) && (totalCnt >= totalCyc)) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.active  = (state != ST_IDLE);
    ctl.strobe  = strobeQ;
    ctl.capture = leaveActive;
    doneOut     = doneQ;
    errOut      = doneQ && errQ;
  end

endmodule

// File: rtl/ataPioDatapath.sv
module ataPioDatapath
  import ataPioPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int CS_W        = 2,
  parameter int NUM_MODES   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        ctl,
  input  logic              reqRnw,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [2:0]        reqMode,
  input  logic              rdyEnable,
  input  logic [DATA_W-1:0] ataDdIn,
  input  logic              ataIordy,
  output logic [2:0]        modeQ,
  output logic              wideQ,
  output logic              rdyEnQ,
  output logic              rdySync,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ataAddr,
  output logic [CS_W-1:0]   ataCsN,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic [DATA_W-1:0] ataDdOut,
  output logic              ataDdOe
);

  localparam int HALF_W = DATA_W / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rnwQ;
  logic [ADDR_W-1:0]      addrQ;
  logic [CS_W-1:0]        csQ;
  logic [DATA_W-1:0]      wdataQ;
  logic [DATA_W-1:0]      rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], ataIordy};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rnwQ   <= 1'b1;
      wideQ  <= 1'b1;
      rdyEnQ <= 1'b0;
      modeQ  <= '0;
      addrQ  <= '0;
      csQ    <= '0;
      wdataQ <= '0;
    end else if (ctl.load) begin
      rnwQ   <= reqRnw;
      wideQ  <= reqWide;
      rdyEnQ <= rdyEnable;
      modeQ  <= (int'(reqMode) >= NUM_MODES) ? 3'd0 : reqMode;
      addrQ  <= reqAddr;
      csQ    <= reqCs;
      wdataQ <= reqWide ? reqWdata : {{(DATA_W-HALF_W){1'b0}}, reqWdata[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else if (ctl.capture && rnwQ)
      rdQ <= wideQ ? ataDdIn : {{(DATA_W-HALF_W){1'b0}}, ataDdIn[HALF_W-1:0]};
  end

  always_comb begin
    rdySync  = syncQ[SYNC_STAGES-1];
    rdData   = rdQ;
    ataAddr  = addrQ;
    ataCsN   = ctl.active ? ~csQ : '1;
    ataDiorN = !(ctl.strobe && rnwQ);
    ataDiowN = !(ctl.strobe && !rnwQ);
    ataDdOut = wdataQ;
    ataDdOe  = ctl.active && !rnwQ;
  end

endmodule

// File: rtl/ataPioSeq.sv
module ataPioSeq
  import ataPioPkg::*;
#(
  parameter int CLK_PS      = 5000,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int CS_W        = 2,
  parameter int NUM_MODES   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqRnw,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [2:0]        reqMode,
  input  logic              rdyEnable,
  output logic              busy,
  output logic              done,
  output logic              timeoutErr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ataAddr,
  output logic [CS_W-1:0]   ataCsN,
  output logic              ataDiorN,
  output logic              ataDiowN,
  output logic [DATA_W-1:0] ataDdOut,
  output logic              ataDdOe,
  input  logic [DATA_W-1:0] ataDdIn,
  input  logic              ataIordy
);

  localparam int WORST_CYC = nsToCyc(600 + 70 + 290 + 35 + 1250 + 70, CLK_PS) + SYNC_STAGES + 8;
  localparam int CNT_W     = $clog2(WORST_CYC + 1);

  ctrlStrobeT       ctl;
  logic [2:0]       modeQ;
  logic             wideQ;
  logic             rdyEnQ;
  logic             rdySync;
  logic [CNT_W-1:0] setupCyc;
  logic [CNT_W-1:0] pulseCyc;
  logic [CNT_W-1:0] negCyc;
  logic [CNT_W-1:0] totalCyc;
  logic [CNT_W-1:0] timeoutCyc;
  logic             honorRdy;

  ataPioTiming #(
    .CLK_PS(CLK_PS), .CNT_W(CNT_W), .NUM_MODES(NUM_MODES), .SYNC_STAGES(SYNC_STAGES),
    .RDY_SAMPLE_NS(35), .RDY_MAX_NS(1250)
  ) uTiming (
    .modeIdx(modeQ), .wide(wideQ), .rdyEn(rdyEnQ),
    .setupCyc(setupCyc), .pulseCyc(pulseCyc), .negCyc(negCyc),
    .totalCyc(totalCyc), .timeoutCyc(timeoutCyc), .honorRdy(honorRdy)
  );

  ataPioCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .setupCyc(setupCyc), .pulseCyc(pulseCyc), .negCyc(negCyc),
    .totalCyc(totalCyc), .timeoutCyc(timeoutCyc), .honorRdy(honorRdy),
    .rdySync(rdySync), .ctl(ctl), .doneOut(done), .errOut(timeoutErr)
  );

  ataPioDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CS_W(CS_W),
    .NUM_MODES(NUM_MODES), .SYNC_STAGES(SYNC_STAGES)
  ) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqRnw(reqRnw), .reqWide(reqWide), .reqAddr(reqAddr), .reqCs(reqCs),
    .reqWdata(reqWdata), .reqMode(reqMode), .rdyEnable(rdyEnable),
    .ataDdIn(ataDdIn), .ataIordy(ataIordy),
    .modeQ(modeQ), .wideQ(wideQ), .rdyEnQ(rdyEnQ), .rdySync(rdySync),
    .rdData(rdData), .ataAddr(ataAddr), .ataCsN(ataCsN),
    .ataDiorN(ataDiorN), .ataDiowN(ataDiowN),
    .ataDdOut(ataDdOut), .ataDdOe(ataDdOe)
  );

  assign busy = ctl.active;

endmodule

// File: rtl/ataPioChecker.sv
module ataPioChecker #(
  parameter int ADDR_W = 3,
  parameter int CS_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              timeoutErr,
  input logic              ataDiorN,
  input logic              ataDiowN,
  input logic              ataDdOe,
  input logic [ADDR_W-1:0] ataAddr,
  input logic [CS_W-1:0]   ataCsN
);

  // R5 / R6: never both strobes at once
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!ataDiorN && !ataDiowN));

  // R5: bus released while reading
  a_r5_read_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !ataDiorN |-> !ataDdOe);

  // R6: bus driven while writing
  a_r6_write_drives: assert property (@(posedge clk) disable iff (!rstN)
    !ataDiowN |-> ataDdOe);

  // R2: address and chip-select stable while a strobe is low
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (!ataDiorN || !ataDiowN)) |-> ($stable(ataAddr) && $stable(ataCsN)));

  // R2: a strobe falls only after a setup cycle within the same busy period
  a_r2_strobe_after_setup: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ataDiorN) || $fell(ataDiowN)) |-> $past(busy));

  // R4: end of busy is marked by done
  a_r4_done_on_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: timeout is reported only at an idle, negated end of cycle
  a_r8_err_at_end: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (done && !busy && ataDiorN && ataDiowN));

endmodule

bind ataPioSeq ataPioChecker #(.ADDR_W(ADDR_W), .CS_W(CS_W)) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .timeoutErr(timeoutErr),
  .ataDiorN(ataDiorN), .ataDiowN(ataDiowN), .ataDdOe(ataDdOe),
  .ataAddr(ataAddr), .ataCsN(ataCsN)
);

// File: tb/tb_ataPioSeq.sv
`timescale 1ns/1ps
module tb_ataPioSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqRnw = 1'b0, reqWide = 1'b0, rdyEnable = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [1:0]  reqCs = '0;
  logic [15:0] reqWdata = '0;
  logic [2:0]  reqMode = '0;
  logic        busy, done, timeoutErr;
  logic [15:0] rdData;
  logic [2:0]  ataAddr;
  logic [1:0]  ataCsN;
  logic        ataDiorN, ataDiowN, ataDdOe;
  logic [15:0] ataDdOut;
  logic [15:0] ataDdIn = '0;
  logic        ataIordy = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ataPioSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRnw(reqRnw), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqCs(reqCs), .reqWdata(reqWdata), .reqMode(reqMode),
    .rdyEnable(rdyEnable), .busy(busy), .done(done), .timeoutErr(timeoutErr),
    .rdData(rdData), .ataAddr(ataAddr), .ataCsN(ataCsN), .ataDiorN(ataDiorN),
    .ataDiowN(ataDiowN), .ataDdOut(ataDdOut), .ataDdOe(ataDdOe),
    .ataDdIn(ataDdIn), .ataIordy(ataIordy)
  );

  int t0Tab[5]  = '{600, 383, 240, 180, 120};
  int t1Tab[5]  = '{70, 50, 30, 30, 25};
  int p16Tab[5] = '{165, 125, 100, 80, 70};
  int p8Tab[5]  = '{290, 290, 290, 80, 70};
  int recTab[5] = '{0, 0, 0, 70, 25};
  int ahTab[5]  = '{20, 15, 10, 10, 10};
  int dhTab[5]  = '{30, 20, 15, 10, 10};

  function automatic int cyc(input int ns);
    return (ns + 4) / 5;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RDY_CYC = 7 + 2;
  localparam int TO_LIMIT = RDY_CYC + 250;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runXfer(input int mode, input bit wide, input bit rnw,
                         input logic [2:0] a, input logic [1:0] c,
                         input logic [15:0] wd, input logic [15:0] dIn,
                         input bit rdyEn, input int relAt,
                         output int su, output int pw, output int bz,
                         output bit err, output bit ok);
    su = 0; pw = 0; bz = 0; err = 0; ok = 1;
    @(negedge clk);
    reqValid = 1; reqMode = 3'(mode); reqWide = wide; reqRnw = rnw;
    reqAddr = a; reqCs = c; reqWdata = wd; rdyEnable = rdyEn; ataDdIn = dIn;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin
        err = timeoutErr;
        break;
      end
      if (busy) bz++;
      if (!ataDiorN || !ataDiowN) begin
        pw++;
        if (rnw ? !(ataDiorN == 0 && ataDiowN == 1) : !(ataDiowN == 0 && ataDiorN == 1)) ok = 0;
        if (relAt >= 0 && pw == relAt) ataIordy = 1;
      end else if (pw == 0) begin
        su++;
      end
      if (busy && (ataAddr != a || ataCsN != ~c || ataDdOe != !rnw)) ok = 0;
      if (busy && !rnw && ataDdOut != (wide ? wd : {8'h00, wd[7:0]})) ok = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int su, pw, bz;
    bit err, ok;
    int expSu, expPw, expBz, waitCnt;
    logic [15:0] expRd;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ataDiorN && ataDiowN, "R1 strobes", {ataDiorN, ataDiowN}, 3);
    chk(ataCsN == 2'b11, "R1 cs", ataCsN, 3);
    chk(!busy && !done && !timeoutErr && !ataDdOe, "R1 status", {busy, done, timeoutErr, ataDdOe}, 0);
    chk(rdData == 16'h0, "R1 rdData", rdData, 0);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5 R6 sweep over every mode, width and direction
    for (int m = 0; m < 5; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int r = 0; r < 2; r++) begin
          logic [15:0] wd, di;
          wd = 16'hA500 ^ 16'(m * 16'h1111 + w * 7 + r);
          di = 16'h5A00 ^ 16'(m * 16'h0F0F + w * 3 + r * 5);
          runXfer(m, w[0], r[0], 3'(m + r), 2'(1 + w), wd, di, 1'b0, -1, su, pw, bz, err, ok);
          expSu = cyc(t1Tab[m]);
          expPw = cyc(w ? p16Tab[m] : p8Tab[m]);
          expBz = imax(expSu + expPw + imax(imax(cyc(ahTab[m]), cyc(dhTab[m])), cyc(recTab[m])),
                       cyc(t0Tab[m]));
          chk(su == expSu, "R2 setup cycles", su, expSu);
          chk(pw == expPw, "R3 strobe cycles", pw, expPw);
          chk(bz == expBz, "R4 busy cycles", bz, expBz);
          chk(!err, "R4 no error", err, 0);
          if (r) begin
            chk(ok, "R5 read strobe/bus", ok, 1);
            expRd = w ? di : {8'h00, di[7:0]};
            chk(rdData == expRd, "R5 read data", rdData, expRd);
          end else begin
            chk(ok, "R6 write strobe/bus/data", ok, 1);
          end
        end
      end
    end

    // R10 out-of-range mode codes use mode 0
    for (int m = 5; m < 8; m++) begin
      runXfer(m, 1'b1, 1'b1, 3'd2, 2'd1, 16'h0, 16'h1234, 1'b0, -1, su, pw, bz, err, ok);
      chk(pw == cyc(p16Tab[0]), "R10 strobe as mode 0", pw, cyc(p16Tab[0]));
      chk(bz == cyc(t0Tab[0]), "R10 busy as mode 0", bz, cyc(t0Tab[0]));
    end

    // R7 IORDY honoured in mode 3 (mandatory)
    ataIordy = 0;
    runXfer(3, 1'b1, 1'b1, 3'd1, 2'd1, 16'h0, 16'hBEEF, 1'b0, 40, su, pw, bz, err, ok);
    chk(pw == 42, "R7 mode 3 wait", pw, 42);
    chk(!err, "R7 mode 3 no error", err, 0);

    // R7 IORDY honoured in mode 0 when enabled
    ataIordy = 0;
    runXfer(0, 1'b1, 1'b0, 3'd3, 2'd2, 16'hC0DE, 16'h0, 1'b1, 40, su, pw, bz, err, ok);
    chk(pw == 42, "R7 mode 0 enabled wait", pw, 42);

    // R7 IORDY ignored in mode 1 when not enabled
    ataIordy = 0;
    runXfer(1, 1'b1, 1'b1, 3'd4, 2'd1, 16'h0, 16'h7777, 1'b0, -1, su, pw, bz, err, ok);
    chk(pw == cyc(p16Tab[1]), "R7 mode 1 ignores IORDY", pw, cyc(p16Tab[1]));
    chk(!err, "R7 mode 1 no error", err, 0);

    // R7 minimum sample point stretches a short strobe? (mode 2 enabled, ready high)
    ataIordy = 1;
    repeat (3) @(negedge clk);
    runXfer(2, 1'b1, 1'b1, 3'd5, 2'd1, 16'h0, 16'h0101, 1'b1, -1, su, pw, bz, err, ok);
    chk(pw == imax(cyc(p16Tab[2]), RDY_CYC), "R7 mode 2 enabled ready", pw, imax(cyc(p16Tab[2]), RDY_CYC));

    // R8 IORDY stuck low in mode 4 -> timeout
    ataIordy = 0;
    runXfer(4, 1'b1, 1'b1, 3'd6, 2'd1, 16'h0, 16'h4444, 1'b0, -1, su, pw, bz, err, ok);
    chk(pw == TO_LIMIT, "R8 timeout strobe length", pw, TO_LIMIT);
    chk(err, "R8 timeout flagged", err, 1);

    // R9 ready arrives exactly at the timeout limit
    ataIordy = 0;
    runXfer(4, 1'b1, 1'b1, 3'd7, 2'd1, 16'h0, 16'h9999, 1'b0, TO_LIMIT - 2, su, pw, bz, err, ok);
    chk(pw == TO_LIMIT, "R9 ready at limit length", pw, TO_LIMIT);
    chk(!err, "R9 ready wins over timeout", err, 1'b0);
    ataIordy = 1;
    repeat (3) @(negedge clk);

    // R11 request during busy is ignored
    @(negedge clk);
    reqValid = 1; reqMode = 3'd4; reqWide = 1; reqRnw = 0; reqAddr = 3'd5; reqCs = 2'd1;
    reqWdata = 16'h1357;
    @(negedge clk);
    reqValid = 0;
    repeat (8) @(negedge clk);
    reqValid = 1; reqAddr = 3'd2;
    @(negedge clk);
    reqValid = 0;
    chk(ataAddr == 3'd5, "R11 busy request ignored (addr)", ataAddr, 5);
    waitCnt = 0;
    while (!done && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (3) @(negedge clk);
    chk(!busy, "R11 no extra cycle started", busy, 0);

    // R11 request held across a cycle; a new one present in the done cycle starts next
    reqValid = 1; reqAddr = 3'd1; reqRnw = 1; reqMode = 3'd4;
    @(negedge clk);
    waitCnt = 0;
    while (!done && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    reqAddr = 3'd6;
    @(negedge clk);
    chk(busy, "R11 accepted in done cycle", busy, 1);
    chk(ataAddr == 3'd6, "R11 new address", ataAddr, 6);
    reqValid = 0;
    waitCnt = 0;
    while (!done && waitCnt < 1000) begin
      @(negedge clk);
      waitCnt++;
    end
    repeat (2) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule